// File: doc/BRIEF.md
# Break and Reset Entry Sequencer

This block carries a CPU through its exception entry. The CPU has a 32-bit program counter and a 16-bit memory data bus. A break stacks the program counter and the status word on a descending 16-bit stack. The block then reads a 32-bit vector as two 16-bit words, loads the program counter from that vector and fetches the first opcode of the handler. The block owns the program counter, the stack pointer, an operand-address register, the opcode register and a write-hold flag. It drives the memory address, the write data and the write strobe.

Reset is not a separate path. A synchronous reset places a fixed reset opcode in the opcode register, whose selector field picks the reset vector. It also raises the write-hold flag and starts the same break sequence at once. The three stack cycles still run and still move the stack pointer, but they write nothing. The hold drops on the opcode fetch that ends this first sequence. When the sequence is done the block waits in an idle state until a new break request arrives.

Memory is read in the same cycle the address is presented: `mem_rdata` must reflect `mem_addr` combinationally before the clock edge that ends the cycle.

Top module: `brk_entry_seq`

## Requirements
- R1: While `rst` is high the block loads opcode 16'h0100, sets `wr_hold`=1, sets SP to 16'h0001 and PC to 0. In the first cycle after `rst` falls, `busy`=1, `mem_addr`=32'h0000_0001 and `mem_we`=0.
- R2: A break runs three stack cycles. In order they write PC[31:16], PC[15:0] and `status_in`. Each cycle has `mem_addr`={16'h0,SP} and `mem_we`=1 when `wr_hold`=0, and each decrements SP by one.
- R3: While `wr_hold`=1 the three stack cycles still occur with the same addresses and the same SP decrements, but `mem_we` stays 0.
- R4: The two vector cycles that follow the stack cycles present {16'h0, 16'hFFFE − 2·sel} and then that address +1. The selector `sel` is 4 bits wide. Reset uses the selector in opcode bits [11:8], which is 1 and gives $FFFC; a requested break uses `brk_sel`, and 0 gives $FFFE.
- R5: The vector word read first becomes bits [31:16] of the target and the second becomes bits [15:0]. The next cycle presents the target on `mem_addr` and loads PC from it.
- R6: The final cycle presents PC on `mem_addr`, loads `opcode` from `mem_rdata` and increments PC. After it `busy`=0, and while idle `mem_addr`=PC and `mem_we`=0.
- R7: `wr_hold` clears on the fetch cycle that ends the reset sequence. A break requested on the first idle cycle that follows writes all three stack words.
- R8: `brk_req` is accepted only while idle, and `brk_sel` is sampled at acceptance. Changes to either during a running sequence have no effect on it.
- R9: SP is 16 bits and wraps on decrement. From reset it passes 16'h0001, 16'h0000 and 16'hFFFF, and ends at 16'hFFFE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; starts the reset entry |
| brk_req | input | 1 | Break request, taken when idle |
| brk_sel | input | 4 | Vector selector for a requested break |
| status_in | input | 16 | Status word stored in the third stack cycle |
| mem_rdata | input | 16 | Read data for the current address |
| mem_addr | output | 32 | Memory address |
| mem_wdata | output | 16 | Memory write data |
| mem_we | output | 1 | Memory write strobe |
| pc | output | 32 | Program counter |
| sp | output | 16 | Stack pointer |
| opcode | output | 16 | Opcode register |
| wr_hold | output | 1 | Write-hold flag |
| busy | output | 1 | Sequence in progress |

## Verification
Two events can fall in the same cycle. One is the release of the write hold on the reset fetch, and the other is acceptance of a new break on the idle cycle right after it. The bench raises `brk_req` on the first idle cycle after reset and expects all three stack writes of that break to land, with the right addresses and data. A second pairing drives a request and a new selector while a break is already stacking. The vector address read later in that sequence must still come from the selector sampled at acceptance.

// File: rtl/brk_seq_pkg.sv
package brk_seq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PUSH_HI,
    ST_PUSH_LO,
    ST_PUSH_ST,
    ST_VEC_A,
    ST_VEC_B,
    ST_JUMP,
    ST_FETCH
  } seq_st_e;

  function automatic logic is_push(input seq_st_e s);
    return (s == ST_PUSH_HI) || (s == ST_PUSH_LO) || (s == ST_PUSH_ST);
  endfunction
endpackage

// File: rtl/brk_seq_ctrl.sv
module brk_seq_ctrl
  import brk_seq_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    brk_req,
  output seq_st_e st,
  output logic    accept
);
  seq_st_e st_nx;

  assign accept = (st == ST_IDLE) && brk_req;

  always_comb begin
    st_nx = st;
    case (st)
      ST_IDLE:    if (brk_req) st_nx = ST_PUSH_HI;
      ST_PUSH_HI: st_nx = ST_PUSH_LO;
      ST_PUSH_LO: st_nx = ST_PUSH_ST;
      ST_PUSH_ST: st_nx = ST_VEC_A;
      ST_VEC_A:   st_nx = ST_VEC_B;
      ST_VEC_B:   st_nx = ST_JUMP;
      ST_JUMP:    st_nx = ST_FETCH;
      ST_FETCH:   st_nx = ST_IDLE;
      default:    st_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) st <= ST_PUSH_HI;
    else     st <= st_nx;
  end
endmodule

// File: rtl/brk_seq_regs.sv
module brk_seq_regs
  import brk_seq_pkg::*;
#(
  parameter int          DW         = 16,
  parameter int          SW         = 16,
  parameter int          SELW       = 4,
  parameter int          SEL_LSB    = 8,
  parameter logic [15:0] RST_OPCODE = 16'h0100,
  parameter logic [15:0] SP_RESET   = 16'h0001,
  parameter logic [31:0] PC_RESET   = 32'h0000_0000
) (
  input  logic            clk,
  input  logic            rst,
  input  seq_st_e         st,
  input  logic            accept,
  input  logic [SELW-1:0] brk_sel,
  input  logic [DW-1:0]   mem_rdata,
  output logic [2*DW-1:0] pc,
  output logic [SW-1:0]   sp,
  output logic [2*DW-1:0] oar,
  output logic [DW-1:0]   opcode,
  output logic [SELW-1:0] vsel,
  output logic            hold
);
  localparam int AW = 2 * DW;

  always_ff @(posedge clk) begin
    if (rst) begin
      pc     <= AW'(PC_RESET);
      sp     <= SW'(SP_RESET);
      oar    <= '0;
      opcode <= DW'(RST_OPCODE);
      vsel   <= RST_OPCODE[SEL_LSB +: SELW];
      hold   <= 1'b1;
    end else begin
      case (st)
        ST_IDLE:  if (accept) vsel <= brk_sel;
        ST_PUSH_HI, ST_PUSH_LO, ST_PUSH_ST: sp <= sp - SW'(1);
        ST_VEC_A: oar <= {{DW{1'b0}}, mem_rdata};
        ST_VEC_B: oar <= {oar[DW-1:0], mem_rdata};
        ST_JUMP:  pc  <= oar;
        ST_FETCH: begin
          opcode <= mem_rdata;
          pc     <= pc + AW'(1);
          hold   <= 1'b0;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/brk_seq_bus.sv
module brk_seq_bus
  import brk_seq_pkg::*;
#(
  parameter int          DW       = 16,
  parameter int          SW       = 16,
  parameter int          SELW     = 4,
  parameter logic [15:0] VEC_BASE = 16'hFFFE
) (
  input  seq_st_e         st,
  input  logic [2*DW-1:0] pc,
  input  logic [SW-1:0]   sp,
  input  logic [2*DW-1:0] oar,
  input  logic [SELW-1:0] vsel,
  input  logic            hold,
  input  logic [DW-1:0]   status_in,
  output logic [2*DW-1:0] mem_addr,
  output logic [DW-1:0]   mem_wdata,
  output logic            mem_we
);
  localparam int AW = 2 * DW;
  logic [DW-1:0] vec_lo;

  assign vec_lo = DW'(VEC_BASE) - (DW'(vsel) << 1);

  always_comb begin
    mem_addr  = pc;
    mem_wdata = '0;
    mem_we    = 1'b0;
    if (is_push(st)) begin
      mem_addr = AW'(sp);
      mem_we   = !hold;
    end
    case (st)
      ST_PUSH_HI: mem_wdata = pc[AW-1:DW];
      ST_PUSH_LO: mem_wdata = pc[DW-1:0];
      ST_PUSH_ST: mem_wdata = status_in;
      ST_VEC_A:   mem_addr  = AW'(vec_lo);
      ST_VEC_B:   mem_addr  = AW'(vec_lo) + AW'(1);
      ST_JUMP:    mem_addr  = oar;
      default: ;
    endcase
  end
endmodule

// File: rtl/brk_entry_seq.sv
module brk_entry_seq
  import brk_seq_pkg::*;
#(
  parameter int          DW         = 16,
  parameter int          SW         = 16,
  parameter int          SELW       = 4,
  parameter int          SEL_LSB    = 8,
  parameter logic [15:0] VEC_BASE   = 16'hFFFE,
  parameter logic [15:0] RST_OPCODE = 16'h0100,
  parameter logic [15:0] SP_RESET   = 16'h0001,
  parameter logic [31:0] PC_RESET   = 32'h0000_0000
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            brk_req,
  input  logic [SELW-1:0] brk_sel,
  input  logic [DW-1:0]   status_in,
  input  logic [DW-1:0]   mem_rdata,
  output logic [2*DW-1:0] mem_addr,
  output logic [DW-1:0]   mem_wdata,
  output logic            mem_we,
  output logic [2*DW-1:0] pc,
  output logic [SW-1:0]   sp,
  output logic [DW-1:0]   opcode,
  output logic            wr_hold,
  output logic            busy
);
  localparam int AW = 2 * DW;

  seq_st_e         seq_st;
  logic            accept;
  logic [AW-1:0]   oar;
  logic [SELW-1:0] vsel;

  brk_seq_ctrl u_ctrl (
    .clk(clk), .rst(rst), .brk_req(brk_req), .st(seq_st), .accept(accept)
  );

  brk_seq_regs #(
    .DW(DW), .SW(SW), .SELW(SELW), .SEL_LSB(SEL_LSB),
    .RST_OPCODE(RST_OPCODE), .SP_RESET(SP_RESET), .PC_RESET(PC_RESET)
  ) u_regs (
    .clk(clk), .rst(rst), .st(seq_st), .accept(accept), .brk_sel(brk_sel),
    .mem_rdata(mem_rdata), .pc(pc), .sp(sp), .oar(oar), .opcode(opcode),
    .vsel(vsel), .hold(wr_hold)
  );

  brk_seq_bus #(
    .DW(DW), .SW(SW), .SELW(SELW), .VEC_BASE(VEC_BASE)
  ) u_bus (
    .st(seq_st), .pc(pc), .sp(sp), .oar(oar), .vsel(vsel), .hold(wr_hold),
    .status_in(status_in), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_we(mem_we)
  );

  assign busy = (seq_st != ST_IDLE);
endmodule

// File: rtl/brk_entry_seq_chk.sv
module brk_entry_seq_chk
  import brk_seq_pkg::*;
(
  input logic        clk,
  input logic        rst,
  input seq_st_e     seq_st,
  input logic [31:0] mem_addr,
  input logic        mem_we,
  input logic [31:0] pc,
  input logic [15:0] sp,
  input logic        wr_hold,
  input logic        busy
);
  // R2
  we_sp_dec_chk: assert property (@(posedge clk) disable iff (rst)
    mem_we |=> sp == $past(sp) - 16'd1);
  // R3
  hold_no_write_chk: assert property (@(posedge clk) disable iff (rst)
    wr_hold |-> !mem_we);
  // R5
  jump_pc_chk: assert property (@(posedge clk) disable iff (rst)
    (seq_st == ST_JUMP) |=> pc == $past(mem_addr));
  // R6
  fetch_end_chk: assert property (@(posedge clk) disable iff (rst)
    (seq_st == ST_FETCH) |=> (!busy && pc == $past(pc) + 32'd1));
  // R7
  hold_release_chk: assert property (@(posedge clk) disable iff (rst)
    (seq_st == ST_FETCH) |=> !wr_hold);
  // R6
  idle_addr_chk: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (mem_addr == pc && !mem_we));
endmodule

bind brk_entry_seq brk_entry_seq_chk u_chk (
  .clk(clk), .rst(rst), .seq_st(seq_st), .mem_addr(mem_addr), .mem_we(mem_we),
  .pc(pc), .sp(sp), .wr_hold(wr_hold), .busy(busy)
);

// File: tb/tb_brk_entry_seq.sv
`timescale 1ns/1ps
module tb_brk_entry_seq;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        brk_req = 1'b0;
  logic [3:0]  brk_sel = 4'd0;
  logic [15:0] status_in = 16'h00A5;
  logic [15:0] mem_rdata;
  logic [31:0] mem_addr, pc;
  logic [15:0] mem_wdata, sp, opcode;
  logic        mem_we, wr_hold, busy;

  always #5 clk = ~clk;

  brk_entry_seq dut (
    .clk(clk), .rst(rst), .brk_req(brk_req), .brk_sel(brk_sel),
    .status_in(status_in), .mem_rdata(mem_rdata), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_we(mem_we), .pc(pc), .sp(sp),
    .opcode(opcode), .wr_hold(wr_hold), .busy(busy)
  );

  function automatic logic [15:0] mem_rd(input logic [31:0] a);
    case (a)
      32'hFFFC: return 16'h0012;
      32'hFFFD: return 16'h3400;
      32'hFFFE: return 16'hABCD;
      32'hFFFF: return 16'h0010;
      32'hFFFA: return 16'h0000;
      32'hFFFB: return 16'h0200;
      default:  return a[15:0] ^ 16'hC3A5;
    endcase
  endfunction

  assign mem_rdata = mem_rd(mem_addr);

  int total = 0, bad = 0;
  bit reported = 0;
  // reference model state
  int          m_ph = 0;
  logic [31:0] m_pc, m_oar;
  logic [15:0] m_sp, m_op;
  logic [3:0]  m_sel;
  bit          m_hold, m_live = 0;
  logic [31:0] wa_q[$];
  logic [15:0] wd_q[$];
  logic [31:0] vec_seen;

  function automatic logic [31:0] m_vec();
    return {16'h0, 16'hFFFE - {11'b0, m_sel, 1'b0}};
  endfunction

  function automatic logic [31:0] m_addr();
    case (m_ph)
      1, 2, 3: return {16'h0, m_sp};
      4: return m_vec();
      5: return m_vec() + 32'd1;
      6: return m_oar;
      default: return m_pc;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp, input string what);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic report();
    if (!reported) begin
      reported = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  // model update
  always @(posedge clk) begin
    if (rst) begin
      m_ph = 1; m_sp = 16'h0001; m_pc = 0; m_oar = 0;
      m_op = 16'h0100; m_sel = 4'd1; m_hold = 1; m_live = 1;
    end else if (m_live) begin
      logic [15:0] rd;
      rd = mem_rd(m_addr());
      if (m_ph == 4) vec_seen = m_addr();
      case (m_ph)
        0: if (brk_req) begin m_sel = brk_sel; m_ph = 1; end
        1, 2, 3: begin m_sp = m_sp - 16'd1; m_ph++; end
        4: begin m_oar = {16'h0, rd}; m_ph++; end
        5: begin m_oar = {m_oar[15:0], rd}; m_ph++; end
        6: begin m_pc = m_oar; m_ph++; end
        default: begin m_op = rd; m_pc = m_pc + 32'd1; m_hold = 0; m_ph = 0; end
      endcase
    end
    if (!rst && mem_we) begin wa_q.push_back(mem_addr); wd_q.push_back(mem_wdata); end
  end

  // per-cycle comparison
  always @(negedge clk) begin
    if (!rst && m_live) begin
      string tag;
      logic [15:0] ewd;
      case (m_ph)
        1, 2, 3: tag = m_hold ? "R3" : "R2";
        4, 5: tag = "R4";
        6: tag = "R5";
        7: tag = "R6";
        default: tag = "R8";
      endcase
      case (m_ph)
        1: ewd = m_pc[31:16];
        2: ewd = m_pc[15:0];
        3: ewd = status_in;
        default: ewd = 16'h0;
      endcase
      chk(tag, {mem_addr, mem_wdata, 15'b0, mem_we},
          {m_addr(), ewd, 15'b0, (m_ph >= 1 && m_ph <= 3 && !m_hold)}, "addr/wdata/we");
      chk(tag, {pc, sp, opcode}, {m_pc, m_sp, m_op}, "pc/sp/opcode");
      chk(tag, {62'b0, wr_hold, busy}, {62'b0, m_hold, (m_ph != 0)}, "hold/busy");
    end
  end

  task automatic wait_idle();
    do @(negedge clk); while (busy);
  endtask

  initial begin
    #200000;
    total++; bad++;
    $display("FAIL watchdog timeout actual=running expected=finished");
    report();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    // R1: first cycle after reset release
    chk("R1", {62'b0, wr_hold, mem_we}, {62'b0, 1'b1, 1'b0}, "hold/we");
    chk("R1", {opcode, 15'b0, busy}, {16'h0100, 15'b0, 1'b1}, "opcode/busy");
    chk("R1", mem_addr, 32'h0000_0001, "first stack address");
    @(negedge clk);
    @(negedge clk);
    @(negedge clk);
    // R4: reset vector address on first vector cycle
    chk("R4", mem_addr, 32'h0000_FFFC, "reset vector address");
    wait_idle();
    chk("R9", sp, 16'hFFFE, "sp after wrap");
    chk("R5", pc, 32'h0012_3401, "pc after reset");
    chk("R3", wa_q.size(), 0, "writes during reset");
    // R7: break on first idle cycle after reset
    wa_q.delete(); wd_q.delete();
    brk_req = 1'b1; brk_sel = 4'd0;
    @(negedge clk) brk_req = 1'b0;
    wait_idle();
    chk("R7", wa_q.size(), 3, "write count");
    if (wa_q.size() == 3) begin
      chk("R2", {wa_q[0], wa_q[1], wa_q[2]}, {32'hFFFE, 32'hFFFD, 32'hFFFC}, "push addrs");
      chk("R2", {wd_q[0], wd_q[1], wd_q[2]}, {16'h0012, 16'h3401, 16'h00A5}, "push data");
    end
    chk("R4", vec_seen, 32'h0000_FFFE, "break vector address");
    chk("R6", {pc, opcode}, {32'hABCD_0011, mem_rd(32'hABCD_0010)}, "pc/opcode after break");
    // R8: request and selector change during a running sequence
    repeat (2) @(negedge clk);
    status_in = 16'h1234;
    brk_req = 1'b1; brk_sel = 4'd2;
    @(negedge clk) brk_sel = 4'd5;
    repeat (3) @(negedge clk);
    brk_req = 1'b0;
    wait_idle();
    chk("R8", vec_seen, 32'h0000_FFFA, "selector sampled at acceptance");
    chk("R5", pc, 32'h0000_0201, "pc from sel 2 vector");
    // one more break with selector 1
    @(negedge clk) begin brk_req = 1'b1; brk_sel = 4'd1; end
    @(negedge clk) brk_req = 1'b0;
    wait_idle();
    chk("R4", vec_seen, 32'h0000_FFFC, "sel 1 vector address");
    repeat (3) @(negedge clk);
    report();
  end
endmodule